// File: doc/BRIEF.md
# Ping-Pong Width-Converting Sample Streamer

This block moves a long recorded vector from a wide external memory out to a slow, narrow parallel capture port. Memory delivers 144-bit words, each a 128-bit payload with its error-correction bits in the upper part. The block drops those bits and stores the payload in a dual-ported buffer. The buffer has two halves. One half is replayed as 16-bit samples at a fixed slow rate while the other half is refilled, so gaps in memory access never reach the output.

Each sample leaves with a generated sample clock and a valid flag, so external logic can latch it on the rising edge of that clock. A mode input can put an incrementing count on the output in place of buffered data, so the capture path can be tested without memory. If the buffer cannot keep up, valid drops, the last value is held, and a sticky flag records the event.

Top module: `pingpong_streamer`

## Requirements
- R1: Only bits [PAY_W-1:0] of `wr_word` are stored. The upper MEM_W-PAY_W error-correction bits have no effect on any output.
- R2: Buffered samples leave in this order: halves alternate starting with half 0, words go in ascending address order within a half, and lanes go from bits [15:0] upward within a word.
- R3: A new sample is emitted once every PERIOD cycles, on the edge where the internal period counter wraps. `smp_data` and `smp_valid` do not change on any other edge.
- R4: `smp_clk` is low for the first PERIOD/2 cycles after each wrap and high for the remaining PERIOD/2. Data therefore changes on the falling edge of `smp_clk` and is stable at its rising edge.
- R5: `fill_req` is high while the half named by `fill_sel` is not full. That half becomes full after HALF_WORDS accepted writes, and the request then moves to the other half. A drained half is requested again starting on the edge that emits its last sample.
- R6: A write presented while `fill_req` is low is discarded and changes no buffer contents.
- R7: In buffer mode, if the half being read is not full at a sample edge, then `smp_valid` goes to 0, `smp_data` holds its previous value, and `underrun` is set. `underrun` stays set until reset.
- R8: When `pattern_sel`=1 at a sample edge, the sample is a 16-bit count with `smp_valid`=1. The count starts at 0 after reset, steps once per pattern sample, and does not advance the buffer. `pattern_sel` is only sampled on sample edges.
- R9: After reset, `smp_data`=0, `smp_valid`=0, `smp_clk`=0, `underrun`=0, `fill_req`=1 and `fill_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Memory word present on `wr_word` |
| wr_word | input | MEM_W | Memory word: payload in the low PAY_W bits, ECC above them |
| fill_req | output | 1 | Buffer wants words for half `fill_sel` |
| fill_sel | output | 1 | Half currently being refilled |
| pattern_sel | input | 1 | 1 selects the count pattern, 0 selects buffered data |
| smp_clk | output | 1 | Generated sample clock, 50% duty over PERIOD cycles |
| smp_valid | output | 1 | Current sample is valid |
| smp_data | output | SMP_W | Output sample |
| underrun | output | 1 | Sticky starvation flag |

## Verification
Two events can land in the same cycle: a write into one half, and the emission of a sample whose data was read from the other half. The hardest case comes right after a half drains. The bench starts refilling half 0 on the first cycle its request is visible, which is the cycle the last sample of that half leaves. The bench then checks every following sample against arithmetic expectations, so corruption of the half still being read would show. Pattern samples are also emitted while both halves fill, and a short mid-period mode pulse shows that only the value at the sample edge counts.

// File: rtl/pps_pkg.sv
package pps_pkg;
    // Output source chosen at each sample edge.
    typedef enum logic {
        SRC_BUFFER  = 1'b0,
        SRC_PATTERN = 1'b1
    } src_e;
endpackage

// File: rtl/pps_pacer.sv
module pps_pacer #(
    parameter int PERIOD = 512,
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic sclk
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } pace_t;

    pace_t q, d;

    always_comb begin
        d    = q;
        tick = (q.cnt == CW'(PERIOD - 1));
        if (tick) d.cnt = '0;
        else      d.cnt = q.cnt + CW'(1);
        d.sclk = (d.cnt >= CW'(PERIOD / 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;

    // R3/R4: every wrap starts a period with the sample clock low
    p_wrap_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (q.cnt == '0 && !q.sclk));

    // R4: the rising edge comes halfway through the period
    p_rise_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sclk) |-> (q.cnt == CW'(PERIOD / 2)));
endmodule

// File: rtl/pps_buffer.sv
module pps_buffer #(
    parameter int PAY_W = 128,
    parameter int SMP_W = 16,
    parameter int WORDS = 1024,
    localparam int LANES = PAY_W / SMP_W,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WAW   = $clog2(WORDS),
    localparam int RAW   = WAW + LW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WAW-1:0]   waddr,
    input  logic [PAY_W-1:0] wdata,
    input  logic [RAW-1:0]   raddr,
    output logic [SMP_W-1:0] rdata
);
    logic [PAY_W-1:0] mem [WORDS];
    logic [PAY_W-1:0] word_q;
    logic [LW-1:0]    lane_q;

    // Wide write port, registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        word_q <= mem[raddr[RAW-1:LW]];
        lane_q <= raddr[LW-1:0];
    end

    // Narrow view: pick a 16-bit lane, lowest lane first in address order.
    assign rdata = word_q[lane_q * SMP_W +: SMP_W];
endmodule

// File: rtl/pps_fill.sv
module pps_fill #(
    parameter int MEM_W      = 144,
    parameter int PAY_W      = 128,
    parameter int HALF_WORDS = 512,
    localparam int HW_W = $clog2(HALF_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [MEM_W-1:0] wr_word,
    input  logic             drain,
    input  logic             drain_half,
    output logic             req,
    output logic             fill_half,
    output logic [1:0]       full,
    output logic             we,
    output logic [HW_W:0]    waddr,
    output logic [PAY_W-1:0] wdata
);
    typedef struct packed {
        logic [1:0]      full;
        logic            half;
        logic [HW_W-1:0] ptr;
    } fill_t;

    fill_t q, d;
    logic  ecc_unused;

    // Error-correction bits are dropped here.
    assign ecc_unused = ^wr_word[MEM_W-1:PAY_W];
    assign wdata      = wr_word[PAY_W-1:0];

    always_comb begin
        d     = q;
        req   = !q.full[q.half];
        we    = wr_valid && req;
        waddr = {q.half, q.ptr};
        if (drain) d.full[drain_half] = 1'b0;
        if (we) begin
            if (q.ptr == HW_W'(HALF_WORDS - 1)) begin
                d.ptr          = '0;
                d.full[q.half] = 1'b1;
                d.half         = ~q.half;
            end else begin
                d.ptr = q.ptr + HW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fill_half = q.half;
    assign full      = q.full;

    // R5: only a full half is ever drained
    p_drain_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> q.full[drain_half]);

    for (genvar g = 0; g < 2; g++) begin : g_half
        // R5: a full half stays full until the reader drains it
        p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (q.full[g] && !(drain && drain_half == 1'(g))) |=> q.full[g]);
    end
endmodule

// File: rtl/pingpong_streamer.sv
module pingpong_streamer #(
    parameter int MEM_W      = 144,
    parameter int PAY_W      = 128,
    parameter int SMP_W      = 16,
    parameter int HALF_WORDS = 512,
    parameter int PERIOD     = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [MEM_W-1:0] wr_word,
    output logic             fill_req,
    output logic             fill_sel,
    input  logic             pattern_sel,
    output logic             smp_clk,
    output logic             smp_valid,
    output logic [SMP_W-1:0] smp_data,
    output logic             underrun
);
    import pps_pkg::*;

    localparam int LANES = PAY_W / SMP_W;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int HW_W  = $clog2(HALF_WORDS);
    localparam int WORDS = 2 * HALF_WORDS;
    localparam int PW    = 1 + HW_W + LW;

    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [SMP_W-1:0] data;
        logic             valid;
        logic             under;
        logic [SMP_W-1:0] pat;
    } rd_t;

    rd_t q, d;

    logic             tick;
    logic             drain;
    logic             drain_half;
    logic [1:0]       full;
    logic             we;
    logic [HW_W:0]    waddr;
    logic [PAY_W-1:0] wdata;
    logic [SMP_W-1:0] rdata;
    logic             rd_half;

    pps_pacer #(.PERIOD(PERIOD)) u_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(smp_clk)
    );

    pps_fill #(.MEM_W(MEM_W), .PAY_W(PAY_W), .HALF_WORDS(HALF_WORDS)) u_fill (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .drain(drain), .drain_half(drain_half), .req(fill_req),
        .fill_half(fill_sel), .full(full), .we(we), .waddr(waddr), .wdata(wdata)
    );

    pps_buffer #(.PAY_W(PAY_W), .SMP_W(SMP_W), .WORDS(WORDS)) u_buf (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(q.ptr), .rdata(rdata)
    );

    assign rd_half = q.ptr[PW-1];

    always_comb begin
        d          = q;
        drain      = 1'b0;
        drain_half = rd_half;
        if (tick) begin
            if (src_e'(pattern_sel) == SRC_PATTERN) begin
                d.data  = q.pat;
                d.valid = 1'b1;
                d.pat   = q.pat + SMP_W'(1);
            end else if (full[rd_half]) begin
                d.data  = rdata;
                d.valid = 1'b1;
                d.ptr   = q.ptr + PW'(1);
                drain   = &q.ptr[PW-2:0];
            end else begin
                d.valid = 1'b0;
                d.under = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign smp_data  = q.data;
    assign smp_valid = q.valid;
    assign underrun  = q.under;

    // R3: outputs only move on a sample edge
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(smp_data) && $stable(smp_valid)));

    // R7: underrun is sticky
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R7: an invalid sample is always accompanied by the underrun flag
    p_starve_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !smp_valid) |-> underrun);

    // R8: a pattern sample is always valid
    p_pattern_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(pattern_sel)) |-> smp_valid);

    // R6: a write never lands in the half being read
    p_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && full[rd_half]) |-> (waddr[HW_W] != rd_half));
endmodule

// File: tb/sim_pingpong_streamer.sv
module sim_pingpong_streamer;
    localparam int P   = 8;
    localparam int H   = 4;
    localparam int MW  = 144;
    localparam int PW  = 128;
    localparam int SW  = 16;
    localparam int EW  = MW - PW;
    localparam int LN  = PW / SW;
    localparam int SPH = H * LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [MW-1:0] wr_word = '0;
    logic          pattern_sel = 1'b1;
    logic          fill_req, fill_sel, smp_clk, smp_valid, underrun;
    logic [SW-1:0] smp_data;

    pingpong_streamer #(.MEM_W(MW), .PAY_W(PW), .SMP_W(SW),
                        .HALF_WORDS(H), .PERIOD(P)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .fill_req(fill_req), .fill_sel(fill_sel), .pattern_sel(pattern_sel),
        .smp_clk(smp_clk), .smp_valid(smp_valid), .smp_data(smp_data),
        .underrun(underrun)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] word_of(input int f, input int w);
        logic [MW-1:0] v;
        for (int l = 0; l < LN; l++) v[l*SW +: SW] = SW'(f * 256 + w * 16 + l + 1);
        v[MW-1:PW] = EW'(16'hC3A5 ^ (f * 7 + w));
        return v;
    endfunction

    function automatic int exp_buf(input int b);
        return (b / SPH) * 256 + ((b % SPH) / LN) * 16 + (b % LN) + 1;
    endfunction

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Main: reset state, mode schedule, summary
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(smp_valid == 1'b0, "R9 valid", smp_valid, 0);
        check(smp_data == '0,    "R9 data", smp_data, 0);
        check(smp_clk == 1'b0,   "R9 sclk", smp_clk, 0);
        check(underrun == 1'b0,  "R9 underrun", underrun, 0);
        check(fill_req == 1'b1,  "R9 fill_req", fill_req, 1);
        check(fill_sel == 1'b0,  "R9 fill_sel", fill_sel, 0);
        rst_n = 1'b1;
        wait_cyc(5 * P + 2);  pattern_sel = 1'b0;   // R8: mid-period pulse, ignored
        wait_cyc(5 * P + 5);  pattern_sel = 1'b1;
        wait_cyc(10 * P + 3); pattern_sel = 1'b0;
        wait_cyc(110 * P + 2); pattern_sel = 1'b1;
        wait_cyc(111 * P + 2); pattern_sel = 1'b0;
        wait_cyc(113 * P + 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    // Feeder: fills, discarded writes, refill on request
    initial begin
        wait (rst_n);
        @(negedge clk);
        for (int f = 0; f < 2; f++) begin
            for (int w = 0; w < H; w++) begin
                check(fill_req == 1'b1, "R5 req while filling", fill_req, 1);
                check(fill_sel == 1'(f), "R5 fill half", fill_sel, f);
                wr_valid = 1'b1;
                wr_word  = word_of(f, w);
                @(negedge clk);
            end
        end
        check(fill_req == 1'b0, "R5 req low when both full", fill_req, 0);
        wr_word = '1;                      // R6: writes that must be discarded
        repeat (20) @(negedge clk);
        wr_valid = 1'b0;
        while (!fill_req) @(negedge clk);
        check(cyc == 42 * P, "R5 half 0 re-request cycle", cyc, 42 * P);
        check(fill_sel == 1'b0, "R5 re-request half", fill_sel, 0);
        for (int w = 0; w < H; w++) begin
            check(fill_req == 1'b1, "R5 req during refill", fill_req, 1);
            wr_valid = 1'b1;
            wr_word  = word_of(2, w);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        check(fill_req == 1'b0, "R5 req low after refill", fill_req, 0);
        while (!fill_req) @(negedge clk);
        check(cyc == 74 * P, "R5 half 1 re-request cycle", cyc, 74 * P);
        check(fill_sel == 1'b1, "R5 re-request half 1", fill_sel, 1);
    end

    // Monitor: sample clock shape, per-sample expectations, hold between edges
    initial begin
        logic [SW-1:0] pd;
        logic          pv;
        pd = '0;
        pv = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            begin
                int k;
                k = cyc;
                check(smp_clk == ((k % P) >= P / 2), "R4 sclk", smp_clk, (k % P) >= P / 2);
                if (k % P == 0) begin
                    int s, ed;
                    bit ev;
                    s = k / P - 1;
                    if (s <= 9)        begin ev = 1; ed = s; end
                    else if (s <= 105) begin ev = 1; ed = exp_buf(s - 10); end
                    else if (s <= 109) begin ev = 0; ed = exp_buf(95); end
                    else if (s == 110) begin ev = 1; ed = 10; end
                    else               begin ev = 0; ed = 10; end
                    if (s <= 9 || s == 110) begin
                        check(smp_valid == ev, "R8 pattern valid", smp_valid, ev);
                        check(smp_data == SW'(ed), "R8 pattern value", smp_data, ed);
                    end else if (s <= 105) begin
                        check(smp_valid == ev, "R2 buffer valid", smp_valid, ev);
                        check(smp_data == SW'(ed), "R1 R2 buffer sample", smp_data, ed);
                    end else begin
                        check(smp_valid == ev, "R7 starved valid", smp_valid, ev);
                        check(smp_data == SW'(ed), "R7 held sample", smp_data, ed);
                    end
                    check(underrun == (s >= 106), "R7 underrun flag", underrun, s >= 106);
                end else begin
                    check(smp_data == pd && smp_valid == pv, "R3 hold between edges",
                          {smp_valid, smp_data}, {pv, pd});
                end
                pd = smp_data;
                pv = smp_valid;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            ntests++;
            $display("FAIL R3 watchdog: got cycle %0d expected below %0d", cyc, 113 * P + 1);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule